// File: doc/BRIEF.md
# Module Descriptor Fetch Unit

This unit switches the processor from one software module to another. It keeps the register that points at the current module's descriptor, a 16-bit byte address because the table of descriptors sits inside the lowest 64 KB of memory. It also keeps a copy of that module's static data base, so that static data accesses never have to read the descriptor again.

A switch is started by presenting a new descriptor address together with a request strobe. A descriptor is four 32-bit words placed at byte offsets 0, 4, 8 and 12. Offset 0 is the static base, offset 4 the link table base, offset 8 the program base, and offset 12 is reserved. The unit reads the first three words, in that order, over a 32-bit read port with a valid/ready handshake. It never reads the reserved word. When the third word arrives, the unit commits all four registers together and pulses a completion strobe. A cancel input abandons a switch in progress, and the previous module context stays intact.

Top module: `moddesc_fetch`

## Requirements
- R1: While reset is asserted, and after it is released until the first completed switch, the descriptor pointer, static base, link table base and program base outputs are zero, and `busy`, `rd_valid` and `sw_done` are low.
- R2: A request seen while `busy` is low sets `busy` on the next cycle. While busy, the unit asserts `rd_valid` for exactly three reads, at offsets 0, 4 and 8 in that order, and never at offset 12. While `busy` is low, `rd_valid` is low.
- R3: Each read address is the 16-bit descriptor address zero-extended to 24 bits, plus the entry offset. For example, descriptor 0xFFF8 reads 0x00FFF8, 0x00FFFC and 0x010000.
- R4: A read transfers on a cycle where `rd_valid` and `rd_ready` are both high, and `rd_rdata` is sampled in that cycle. While `rd_ready` is low and no cancel is given, `rd_valid` stays high and `rd_addr` holds its value.
- R5: On the cycle after the third transfer, `mod_ptr` equals the new descriptor address. `static_base`, `link_base` and `prog_base` show the words read from offsets 0, 4 and 8 respectively.
- R6: The four register outputs change only on the cycle where `sw_done` is high. During a fetch they keep the previous module's values.
- R7: When `sw_cancel` is high on a cycle where `busy` is high, `busy` falls on the next cycle and no `sw_done` follows. All four register outputs keep their previous values, even if a transfer happened in that cycle. `sw_cancel` has no effect while idle.
- R8: A request given while `busy` is high is ignored. The reads continue with the original descriptor address, and the committed pointer is the original one.
- R9: `sw_done` is high for exactly one cycle, the cycle after the third transfer, and `busy` is low in that cycle. A new request may be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req | input | 1 | Request a module switch |
| sw_desc | input | 16 | Descriptor address of the module to switch to |
| sw_cancel | input | 1 | Abandon the switch in progress |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 24 | Byte address of the requested word |
| rd_ready | input | 1 | Memory accepts the read and returns data this cycle |
| rd_rdata | input | 32 | Read data, valid when `rd_valid` and `rd_ready` are high |
| busy | output | 1 | Switch in progress |
| sw_done | output | 1 | One-cycle pulse: new context committed |
| mod_ptr | output | 16 | Descriptor address of the current module |
| static_base | output | 32 | Static data base of the current module |
| link_base | output | 32 | Link table base of the current module |
| prog_base | output | 32 | Program base of the current module |

## Verification
An accepted request shows up as `busy` and the first `rd_valid` exactly one cycle later. Each later address appears one cycle after the previous transfer. The committed registers and the `sw_done` pulse appear one cycle after the third transfer, and a cancel clears `busy` one cycle after it is seen. The bench keeps a behavioural model that takes the inputs applied in each cycle to its state for the next cycle. It compares every output against that model half a cycle after each clock edge, so every result is checked in the one cycle it is due. Stimulus covers memory stalls, ignored requests, cancels at each read, and a descriptor whose reads cross the 64 KB boundary.

// File: rtl/mdf_pkg.sv
// Package: shared constants and types for the module descriptor fetch unit.
// Assumes descriptors hold 32-bit words spaced by ENTRY_BYTES and that the
// first three entries are the only ones the unit consumes.
package mdf_pkg;

    localparam int ENTRY_BYTES = 4;   // spacing of descriptor entries
    localparam int N_FETCH     = 3;   // entries read per switch
    localparam int IDX_W       = 2;   // width of the entry index

    // Entry positions inside a descriptor; the order is the read order.
    localparam int ENT_STATIC  = 0;
    localparam int ENT_LINK    = 1;
    localparam int ENT_PROG    = 2;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_FETCH = 1'b1
    } seq_state_e;

endpackage

// File: rtl/mdf_seq.sv
// Sequencer: accepts a switch request when idle, walks the entry index across
// the fetched entries, handles cancel, and pulses completion.
// Assumes a transfer happens on any cycle with the read valid and ready high;
// a cancel in the same cycle takes priority and discards that transfer.
module mdf_seq
    import mdf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_req,
    input  logic             sw_cancel,
    input  logic             rd_ready,
    output logic             fetching,
    output logic [IDX_W-1:0] entry_idx,
    output logic             accept,
    output logic             beat_take,
    output logic             commit,
    output logic             done_q
);

    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             last_entry;

    // Decode the cycle's events from the state and inputs.
    always_comb begin
        fetching   = (state_q == SEQ_FETCH);
        last_entry = (idx_q == IDX_W'(N_FETCH - 1));
        accept     = !fetching && sw_req;
        beat_take  = fetching && !sw_cancel && rd_ready;
        commit     = beat_take && last_entry;
        entry_idx  = idx_q;
    end

    // Advance the state and entry index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else if (accept) begin
            state_q <= SEQ_FETCH;
            idx_q   <= '0;
        end else if (fetching && sw_cancel) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else if (commit) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else if (beat_take) begin
            idx_q   <= idx_q + 1'b1;
        end
    end

    // Register the completion pulse so it lines up with the new registers.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= commit;
    end

endmodule

// File: rtl/mdf_addr_gen.sv
// Address generator: zero-extends the pending descriptor pointer to the bus
// width and adds the byte offset of the current entry.
// Assumes ADDR_W is wider than PTR_W so the sum may cross the pointer range.
module mdf_addr_gen
    import mdf_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 24
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    localparam int PAD_W = ADDR_W - PTR_W;

    logic [ADDR_W-1:0] base_ext;
    logic [ADDR_W-1:0] offset;

    // Form the widened base and the entry offset, then add them.
    always_comb begin
        base_ext = {{PAD_W{1'b0}}, ptr};
        offset   = ADDR_W'(idx) * ADDR_W'(ENTRY_BYTES);
        addr     = base_ext + offset;
    end

endmodule

// File: rtl/mdf_regbank.sv
// Register bank: holds the pending pointer, stages the early entries of a
// fetch, and commits pointer and bases together when the last entry arrives.
// Assumes the last fetched entry is the program base and bypasses staging.
module mdf_regbank
    import mdf_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [PTR_W-1:0]  new_ptr,
    input  logic              beat_take,
    input  logic [IDX_W-1:0]  entry_idx,
    input  logic [DATA_W-1:0] rd_rdata,
    input  logic              commit,
    output logic [PTR_W-1:0]  pend_ptr,
    output logic [PTR_W-1:0]  mod_q,
    output logic [DATA_W-1:0] sb_q,
    output logic [DATA_W-1:0] lt_q,
    output logic [DATA_W-1:0] pb_q
);

    localparam int N_STAGE = N_FETCH - 1;

    logic [DATA_W-1:0] stage_q [N_STAGE];

    // Capture the requested pointer when a switch is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_ptr <= '0;
        else if (accept) pend_ptr <= new_ptr;
    end

    // One staging register per entry that arrives before the last one.
    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        // Hold entry g until the switch commits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[g] <= '0;
            else if (beat_take && (entry_idx == IDX_W'(g)))
                stage_q[g] <= rd_rdata;
        end
    end

    // Commit the whole context in one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
            sb_q  <= '0;
            lt_q  <= '0;
            pb_q  <= '0;
        end else if (commit) begin
            mod_q <= pend_ptr;
            sb_q  <= stage_q[ENT_STATIC];
            lt_q  <= stage_q[ENT_LINK];
            pb_q  <= rd_rdata;
        end
    end

endmodule

// File: rtl/moddesc_fetch.sv
// Top: module-switch unit. On request it reads the static, link and program
// base entries of a descriptor in low memory, then commits them with the new
// descriptor pointer. Assumes a memory port that returns data in the cycle
// its ready is high.
module moddesc_fetch
    import mdf_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic [PTR_W-1:0]  sw_desc,
    input  logic              sw_cancel,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] rd_rdata,
    output logic              busy,
    output logic              sw_done,
    output logic [PTR_W-1:0]  mod_ptr,
    output logic [DATA_W-1:0] static_base,
    output logic [DATA_W-1:0] link_base,
    output logic [DATA_W-1:0] prog_base
);

    logic             fetching;
    logic [IDX_W-1:0] entry_idx;
    logic             accept;
    logic             beat_take;
    logic             commit;
    logic [PTR_W-1:0] pend_ptr;

    mdf_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_req    (sw_req),
        .sw_cancel (sw_cancel),
        .rd_ready  (rd_ready),
        .fetching  (fetching),
        .entry_idx (entry_idx),
        .accept    (accept),
        .beat_take (beat_take),
        .commit    (commit),
        .done_q    (sw_done)
    );

    mdf_addr_gen #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_addr (
        .ptr  (pend_ptr),
        .idx  (entry_idx),
        .addr (rd_addr)
    );

    mdf_regbank #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .new_ptr   (sw_desc),
        .beat_take (beat_take),
        .entry_idx (entry_idx),
        .rd_rdata  (rd_rdata),
        .commit    (commit),
        .pend_ptr  (pend_ptr),
        .mod_q     (mod_ptr),
        .sb_q      (static_base),
        .lt_q      (link_base),
        .pb_q      (prog_base)
    );

    // Drive the handshake and status from the sequencer state.
    always_comb begin
        rd_valid = fetching;
        busy     = fetching;
    end

endmodule

// File: rtl/moddesc_fetch_chk.sv
// Checker: temporal properties of the module-switch unit, bound to the top.
module moddesc_fetch_chk #(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_req,
    input logic              sw_cancel,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ready,
    input logic              busy,
    input logic              sw_done,
    input logic [PTR_W-1:0]  mod_ptr,
    input logic [DATA_W-1:0] static_base,
    input logic [DATA_W-1:0] link_base,
    input logic [DATA_W-1:0] prog_base
);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sw_req) |=> busy);

    p_idle_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_valid);

    p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !sw_cancel) |=> (rd_valid && $stable(rd_addr)));

    p_regs_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_done |-> ($stable(mod_ptr) && $stable(static_base)
                      && $stable(link_base) && $stable(prog_base)));

    p_cancel_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sw_cancel) |=> (!busy && !sw_done));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_done |-> !busy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_done |=> !sw_done);

endmodule

bind moddesc_fetch moddesc_fetch_chk #(
    .PTR_W(PTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_req      (sw_req),
    .sw_cancel   (sw_cancel),
    .rd_valid    (rd_valid),
    .rd_addr     (rd_addr),
    .rd_ready    (rd_ready),
    .busy        (busy),
    .sw_done     (sw_done),
    .mod_ptr     (mod_ptr),
    .static_base (static_base),
    .link_base   (link_base),
    .prog_base   (prog_base)
);

// File: tb/moddesc_fetch_tb_top.sv
// Bench: behavioural reference model stepped once per clock and compared with
// every output half a cycle after each rising edge.
module moddesc_fetch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_req = 1'b0;
    logic [15:0] sw_desc = '0;
    logic        sw_cancel = 1'b0;
    logic        rd_valid;
    logic [23:0] rd_addr;
    logic        rd_ready = 1'b0;
    logic [31:0] rd_rdata;
    logic        busy;
    logic        sw_done;
    logic [15:0] mod_ptr;
    logic [31:0] static_base;
    logic [31:0] link_base;
    logic [31:0] prog_base;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    // Reference model state
    bit          m_busy = 0;
    bit          m_done = 0;
    int          m_idx = 0;
    logic [15:0] m_pend = '0;
    logic [15:0] m_mod = '0;
    logic [31:0] m_sb = '0, m_lt = '0, m_pb = '0;
    logic [31:0] got[$];
    bit          reset_phase = 1;

    always #10 clk = ~clk;

    // Memory contents: a distinct word per address.
    function automatic logic [31:0] mem_word(input logic [23:0] a);
        return {a[7:0] ^ 8'h5A, a[23:16], a[15:8] ^ 8'hC3, a[7:0]};
    endfunction

    assign rd_rdata = mem_word(rd_addr);

    moddesc_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_desc(sw_desc),
        .sw_cancel(sw_cancel), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_rdata(rd_rdata), .busy(busy),
        .sw_done(sw_done), .mod_ptr(mod_ptr), .static_base(static_base),
        .link_base(link_base), .prog_base(prog_base)
    );

    task automatic chk(input string what, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t",
                     reset_phase ? "R1" : req, what, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] m_addr();
        return {8'h00, m_pend} + 24'(m_idx * 4);
    endfunction

    // One clock: compare, apply inputs, advance the model.
    task automatic step(input bit req, input logic [15:0] desc,
                        input bit cancel, input bit ready);
        @(negedge clk);
        vectors++;
        chk("busy",     "R2", 32'(busy),     32'(m_busy));
        chk("rd_valid", "R2", 32'(rd_valid), 32'(m_busy));
        if (m_busy) chk("rd_addr", "R3", 32'(rd_addr), 32'(m_addr()));
        chk("sw_done",  "R9", 32'(sw_done),  32'(m_done));
        chk("mod_ptr",  "R5", 32'(mod_ptr),  32'(m_mod));
        chk("static_base", "R5", static_base, m_sb);
        chk("link_base",   "R5", link_base,   m_lt);
        chk("prog_base",   "R5", prog_base,   m_pb);
        sw_req = req; sw_desc = desc; sw_cancel = cancel; rd_ready = ready;
        m_done = 0;
        if (!m_busy) begin
            if (req) begin m_busy = 1; m_pend = desc; m_idx = 0; got.delete(); end
        end else if (cancel) begin
            m_busy = 0; got.delete();                    // R7
        end else if (ready) begin
            got.push_back(mem_word(m_addr()));
            if (m_idx == 2) begin
                m_mod = m_pend; m_sb = got[0]; m_lt = got[1]; m_pb = got[2];
                m_busy = 0; m_done = 1; got.delete();
            end else m_idx++;
        end
    endtask

    // Run a switch with memory always ready.
    task automatic run_switch(input logic [15:0] desc);
        step(1, desc, 0, 1);
        for (int i = 0; i < 5; i++) step(0, 16'h0, 0, 1);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); vectors++;
            chk("busy", "R1", 32'(busy), 0);
            chk("mod_ptr", "R1", 32'(mod_ptr), 0);
            chk("static_base", "R1", static_base, 0);
            chk("prog_base", "R1", prog_base, 0);
        end
        rst_n = 1'b1;
        step(0, 16'h0, 0, 1);
        step(0, 16'h0, 1, 1);          // R7: cancel while idle has no effect
        reset_phase = 0;
        run_switch(16'h1230);          // R2 R5 basic switch
        // R4: stalls hold address
        step(1, 16'h0404, 0, 0);
        for (int i = 0; i < 12; i++) step(0, 16'h0, 0, (i % 3) == 2);
        // R8: requests while busy are ignored
        step(1, 16'h2222, 0, 0);
        for (int i = 0; i < 8; i++) step(1, 16'h7777 + 16'(i), 0, i[0]);
        step(0, 16'h0, 0, 1); step(0, 16'h0, 0, 1);
        // R7: cancel at each read position
        for (int c = 0; c < 3; c++) begin
            step(1, 16'h5550 + 16'(c), 0, 1);
            for (int k = 0; k < c; k++) step(0, 16'h0, 0, 1);
            step(0, 16'h0, 1, 1);
            step(0, 16'h0, 0, 1); step(0, 16'h0, 0, 1);
        end
        run_switch(16'hFFF8);          // R3 crossing 64 KB
        run_switch(16'hFFFF);          // R3 odd pointer
        run_switch(16'h0000);
        // R9: back-to-back request in the done cycle
        step(1, 16'h0100, 0, 1); step(0, 16'h0, 0, 1); step(0, 16'h0, 0, 1);
        step(0, 16'h0, 0, 1); step(1, 16'h0200, 0, 1);
        for (int i = 0; i < 4; i++) step(0, 16'h0, 0, 1);
        // Pseudo-random mix
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0] & lf[3], {lf[7:0], lf[15:8]},
                     (lf[5:1] == 5'h1F), lf[2] | lf[9]);
            end
        end
        step(0, 16'h0, 0, 1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule